// File: doc/BRIEF.md
# Wide-Element Predicated Vector Compare

This unit compares a vector of narrow integer elements (8, 16 or 32 bits) against a second vector that is always read as 64-bit lanes. Every narrow element is compared with the single 64-bit lane that covers the same 64-bit segment of the vector. Before the compare, the narrow element is widened to 64 bits. Signed operations sign-extend it and unsigned operations zero-extend it.

The result is a byte-granular predicate. It carries one bit per byte of the vector. Only the bit at the lowest byte of each element is significant, and that bit is gated by a governing predicate that uses the same layout.

The unit decodes its own 32-bit instruction word. It rejects encodings it does not own, and it rejects the doubleword element size, which has no wide form. A request on `valid_i` produces a registered result one cycle later.

Top module: `wcmp_top`

## Requirements
- R1: Every element within 64-bit segment s of `vec_a_i` is compared with bits [64s+63:64s] of `vec_b_i`. No other lane of `vec_b_i` affects that segment's result bits.
- R2: The signed operations GE, GT, LT and LE sign-extend the narrow element to 64 bits and compare it as a two's-complement 64-bit value.
- R3: The unsigned operations HS, HI, LO and LS zero-extend the narrow element and compare it as an unsigned 64-bit value. EQ and NE also zero-extend.
- R4: The instruction is owned when bits [31:24] are 8'h24 and bit 21 is 0. Bits {[15:13],[4]} then select the operation: 0010 EQ, 0011 NE, 0100 GE, 0101 GT, 0110 LT, 0111 LE, 1100 HS, 1101 HI, 1110 LO, 1111 LS. All other values are unclaimed.
- R5: Bits [23:22] give the element size: 0 is byte, 1 is halfword, 2 is word. Size 3 is illegal.
- R6: Result bit k is set only if byte k starts an element and `gov_pred_i[k]` is 1. That means every bit for bytes, even bits for halfwords, and bits at multiples of 4 for words. All other bits are 0.
- R7: For an illegal request, meaning an unowned encoding, an unclaimed operation or size 3, the unit asserts `illegal_o` together with `valid_o`, keeps `pred_we_o` low and drives `pred_o` to 0.
- R8: `valid_o` follows `valid_i` by exactly one cycle, and `pred_we_o` is high only for a legal request. In a cycle after `valid_i` was low, `valid_o`, `pred_we_o` and `illegal_o` are all 0.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| insn_i | input | 32 | Instruction word to decode |
| vec_a_i | input | VLEN | Narrow-element source vector |
| vec_b_i | input | VLEN | Wide 64-bit-lane source vector |
| gov_pred_i | input | VLEN/8 | Governing predicate, one bit per byte |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| pred_o | output | VLEN/8 | Destination predicate |
| pred_we_o | output | 1 | Predicate write enable for a legal request |
| illegal_o | output | 1 | Request was an unallocated encoding |

## Verification
The hardest case to reach is one where a narrow element and its 64-bit lane agree in their low bits but differ once the element is extended. A byte of 0x80 facing a lane of -128 is one example: it is equal under sign extension and far apart under zero extension. Directed vectors place such values under a signed operation and an unsigned operation in turn.

A table of patterns then varies each segment's value with the segment index. This proves that each lane is broadcast only within its own segment. A further directed case perturbs one lane of `vec_b_i` and expects only that segment's bits to change.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;

  localparam int SEG_W = 64;
  localparam int SEG_BYTES = SEG_W / 8;

  typedef enum logic [3:0] {
    OP_EQ, OP_NE, OP_GE, OP_GT, OP_LT, OP_LE,
    OP_HS, OP_HI, OP_LO, OP_LS, OP_BAD
  } cmp_op_e;

  function automatic logic op_is_signed(cmp_op_e op);
    return (op == OP_GE) || (op == OP_GT) || (op == OP_LT) || (op == OP_LE);
  endfunction

  function automatic logic wide_compare(cmp_op_e op, logic [SEG_W-1:0] x, logic [SEG_W-1:0] y);
    logic eq, slt, ult;
    eq  = (x == y);
    slt = ($signed(x) < $signed(y));
    ult = (x < y);
    unique case (op)
      OP_EQ:   return eq;
      OP_NE:   return !eq;
      OP_GE:   return !slt;
      OP_GT:   return !slt && !eq;
      OP_LT:   return slt;
      OP_LE:   return slt || eq;
      OP_HS:   return !ult;
      OP_HI:   return !ult && !eq;
      OP_LO:   return ult;
      OP_LS:   return ult || eq;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wcmp_decode.sv
module wcmp_decode
  import wcmp_pkg::*;
(
  input  logic [31:0] insn_i,
  output cmp_op_e     op_o,
  output logic [1:0]  size_o,
  output logic        illegal_o
);

  always_comb begin
    unique case ({insn_i[15:13], insn_i[4]})
      4'b0010: op_o = OP_EQ;
      4'b0011: op_o = OP_NE;
      4'b0100: op_o = OP_GE;
      4'b0101: op_o = OP_GT;
      4'b0110: op_o = OP_LT;
      4'b0111: op_o = OP_LE;
      4'b1100: op_o = OP_HS;
      4'b1101: op_o = OP_HI;
      4'b1110: op_o = OP_LO;
      4'b1111: op_o = OP_LS;
      default: op_o = OP_BAD;
    endcase
  end

  assign size_o    = insn_i[23:22];
  // doubleword size has no wide form
  assign illegal_o = (insn_i[31:24] != 8'h24) || insn_i[21] ||
                     (size_o == 2'b11) || (op_o == OP_BAD);

endmodule

// File: rtl/wcmp_seg.sv
module wcmp_seg
  import wcmp_pkg::*;
(
  input  logic [SEG_W-1:0]     a_i,
  input  logic [SEG_W-1:0]     b_i,
  input  logic [SEG_BYTES-1:0] gov_i,
  input  logic [1:0]           size_i,
  input  cmp_op_e              op_i,
  output logic [SEG_BYTES-1:0] res_o
);

  logic sgn;
  assign sgn = op_is_signed(op_i);

  for (genvar j = 0; j < SEG_BYTES; j++) begin : g_byte
    localparam int HB = (j / 2) * 2;
    localparam int WB = (j / 4) * 4;
    localparam bit H_LEAD = (j % 2 == 0);
    localparam bit W_LEAD = (j % 4 == 0);

    logic [SEG_W-1:0] ext;
    logic             lead;

    always_comb begin
      unique case (size_i)
        2'd0: begin
          ext  = {{56{sgn & a_i[8*j+7]}}, a_i[8*j +: 8]};
          lead = 1'b1;
        end
        2'd1: begin
          ext  = {{48{sgn & a_i[8*HB+15]}}, a_i[8*HB +: 16]};
          lead = H_LEAD;
        end
        2'd2: begin
          ext  = {{32{sgn & a_i[8*WB+31]}}, a_i[8*WB +: 32]};
          lead = W_LEAD;
        end
        default: begin
          ext  = '0;
          lead = 1'b0;
        end
      endcase
    end

    assign res_o[j] = lead & gov_i[j] & wide_compare(op_i, ext, b_i);
  end

endmodule

// File: rtl/wcmp_top.sv
module wcmp_top
  import wcmp_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [VLEN-1:0]   vec_a_i,
  input  logic [VLEN-1:0]   vec_b_i,
  input  logic [VLEN/8-1:0] gov_pred_i,
  output logic              valid_o,
  output logic [VLEN/8-1:0] pred_o,
  output logic              pred_we_o,
  output logic              illegal_o
);

  localparam int NSEG = VLEN / SEG_W;
  localparam int PW   = VLEN / 8;
  localparam logic [PW-1:0] HALF_GAP = {(PW/2){2'b10}};
  localparam logic [PW-1:0] WORD_GAP = {(PW/4){4'b1110}};

  cmp_op_e       op;
  logic [1:0]    size;
  logic          dec_ill;
  logic [PW-1:0] res;

  wcmp_decode u_dec (
    .insn_i    (insn_i),
    .op_o      (op),
    .size_o    (size),
    .illegal_o (dec_ill)
  );

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    wcmp_seg u_seg (
      .a_i    (vec_a_i[s*SEG_W +: SEG_W]),
      .b_i    (vec_b_i[s*SEG_W +: SEG_W]),
      .gov_i  (gov_pred_i[s*SEG_BYTES +: SEG_BYTES]),
      .size_i (size),
      .op_i   (op),
      .res_o  (res[s*SEG_BYTES +: SEG_BYTES])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      pred_o    <= '0;
      pred_we_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        pred_we_o <= !dec_ill;
        illegal_o <= dec_ill;
        pred_o    <= dec_ill ? '0 : res;
      end else begin
        pred_we_o <= 1'b0;
        illegal_o <= 1'b0;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !pred_we_o && !illegal_o)); // R8
  AST_SIZE3_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[23:22] == 2'b11) |=> (illegal_o && !pred_we_o)); // R5
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!pred_we_o && pred_o == '0 && valid_o)); // R7
  AST_INACTIVE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((pred_o & ~$past(gov_pred_i)) == '0)); // R6
  AST_HALF_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[23:22] == 2'b01) |=> ((pred_o & HALF_GAP) == '0)); // R6
  AST_WORD_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[23:22] == 2'b10) |=> ((pred_o & WORD_GAP) == '0)); // R6

endmodule

// File: tb/tb_wcmp_top.sv
module tb_wcmp_top;

  localparam int VLEN = 256;
  localparam int NSEG = VLEN / 64;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [VLEN-1:0] vec_a_i = '0;
  logic [VLEN-1:0] vec_b_i = '0;
  logic [PW-1:0]   gov_pred_i = '0;
  logic            valid_o, pred_we_o, illegal_o;
  logic [PW-1:0]   pred_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  wcmp_top #(.VLEN(VLEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .vec_a_i(vec_a_i), .vec_b_i(vec_b_i), .gov_pred_i(gov_pred_i),
    .valid_o(valid_o), .pred_o(pred_o), .pred_we_o(pred_we_o), .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [1:0]  size;
    logic [3:0]  sel;
    logic [63:0] a;
    logic [63:0] b;
    logic [31:0] gov;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 4'b0010, 64'h0000000000000005, 64'h0000000000000005, 32'hffffffff},
    '{2'd0, 4'b0011, 64'h0000000000000005, 64'h0000000000000005, 32'hffffffff},
    '{2'd0, 4'b0100, 64'h80ff017f00fe7f80, 64'hffffffffffffff80, 32'hffffffff},
    '{2'd0, 4'b0101, 64'h80ff017f00fe7f80, 64'hffffffffffffff80, 32'hffffffff},
    '{2'd1, 4'b0110, 64'h80007fff0001ffff, 64'h0000000000000000, 32'h0f0fffff},
    '{2'd1, 4'b0111, 64'h80007fff0001ffff, 64'hffffffffffffffff, 32'h0f0fffff},
    '{2'd2, 4'b1100, 64'h8000000000000001, 64'h0000000080000000, 32'hffffffff},
    '{2'd2, 4'b1101, 64'h8000000000000001, 64'h0000000080000000, 32'hffffffff},
    '{2'd2, 4'b1110, 64'hffffffff00000002, 64'h00000000ffffffff, 32'h3333cccc},
    '{2'd2, 4'b1111, 64'hffffffff00000002, 64'h00000000ffffffff, 32'h3333cccc},
    '{2'd1, 4'b1101, 64'h123480000000ffff, 64'h0000000000008000, 32'hffff0000},
    '{2'd0, 4'b1110, 64'h0102030405060708, 64'h0000000000000005, 32'h5a5aa5a5}
  };

  function automatic logic [31:0] mk_insn(logic [1:0] size, logic [3:0] sel);
    return {8'h24, size, 1'b0, 5'd0, sel[3:1], 3'd0, 5'd0, sel[0], 4'd0};
  endfunction

  // expected result from R1..R6
  function automatic logic [PW-1:0] model(logic [1:0] size, logic [3:0] sel,
      logic [VLEN-1:0] a, logic [VLEN-1:0] b, logic [PW-1:0] gov);
    logic [PW-1:0] r;
    bit sgn;
    r = '0;
    sgn = (sel[3:2] == 2'b01);
    for (int s = 0; s < NSEG; s++) begin
      for (int j = 0; j < 8; j++) begin
        int eb, w;
        logic [63:0] e, m, bl;
        bit eq, lt;
        eb = 1 << size;
        if ((j % eb) != 0) continue;
        w = 8 * eb;
        m = (64'h1 << w) - 64'h1;
        e = 64'(a >> (64 * s + 8 * j)) & m;
        if (sgn && e[w-1]) e = e | ~m;
        bl = b[64*s +: 64];
        eq = (e == bl);
        lt = sgn ? ($signed(e) < $signed(bl)) : (e < bl);
        case (sel[2:0])
          3'b010: r[8*s+j] = eq;
          3'b011: r[8*s+j] = !eq;
          3'b100, 3'b100: r[8*s+j] = !lt;
          3'b101: r[8*s+j] = !lt && !eq;
          3'b110: r[8*s+j] = lt;
          3'b111: r[8*s+j] = lt || eq;
          default: r[8*s+j] = 1'b0;
        endcase
        r[8*s+j] = r[8*s+j] & gov[8*s+j];
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] insn, logic [VLEN-1:0] a, logic [VLEN-1:0] b, logic [PW-1:0] gov);
    @(negedge clk);
    valid_i = 1'b1; insn_i = insn; vec_a_i = a; vec_b_i = b; gov_pred_i = gov;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  function automatic logic [VLEN-1:0] spread(logic [63:0] p);
    logic [VLEN-1:0] v;
    for (int s = 0; s < NSEG; s++) v[64*s +: 64] = p + 64'(s);
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid_o", 64'(valid_o), 0);
    check("R9 reset pred_o", 64'(pred_o), 0);
    check("R9 reset pred_we_o/illegal_o", {pred_we_o, illegal_o}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VLEN-1:0] a, b;
      logic [PW-1:0] gov, exp;
      a = spread(TBL[i].a);
      b = spread(TBL[i].b);
      gov = TBL[i].gov;
      exp = model(TBL[i].size, TBL[i].sel, a, b, gov);
      issue(mk_insn(TBL[i].size, TBL[i].sel), a, b, gov);
      check($sformatf("R1/R2/R3/R4/R6 table %0d pred_o", i), 64'(pred_o), 64'(exp));
      check($sformatf("R8 table %0d valid/we", i), {valid_o, pred_we_o, illegal_o}, 3'b110);
    end

    // R2: 0x80 sign-extends to -128, equal to lane
    issue(mk_insn(2'd0, 4'b0100), {PW{8'h80}}, {NSEG{64'hffffffffffffff80}}, '1);
    check("R2 signed GE byte 0x80 vs -128", 64'(pred_o), 64'hffffffff);
    issue(mk_insn(2'd0, 4'b0101), {PW{8'h80}}, {NSEG{64'hffffffffffffff80}}, '1);
    check("R2 signed GT byte 0x80 vs -128", 64'(pred_o), 0);
    // R3: zero-extended 128 is far below the lane
    issue(mk_insn(2'd0, 4'b1100), {PW{8'h80}}, {NSEG{64'hffffffffffffff80}}, '1);
    check("R3 unsigned HS byte 0x80 vs lane", 64'(pred_o), 0);
    issue(mk_insn(2'd0, 4'b1110), {PW{8'h80}}, {NSEG{64'hffffffffffffff80}}, '1);
    check("R3 unsigned LO byte 0x80 vs lane", 64'(pred_o), 64'hffffffff);

    // R6 size masks
    issue(mk_insn(2'd1, 4'b0010), '0, '0, '1);
    check("R6 halfword mask", 64'(pred_o), 64'h55555555);
    issue(mk_insn(2'd2, 4'b0010), '0, '0, '1);
    check("R6 word mask", 64'(pred_o), 64'h11111111);
    issue(mk_insn(2'd0, 4'b0010), '0, '0, 32'h00f0_0f01);
    check("R6 governing predicate", 64'(pred_o), 64'h00f00f01);

    // R1 segment broadcast: each segment's words equal the segment index
    begin
      logic [VLEN-1:0] a, b;
      for (int s = 0; s < NSEG; s++) begin
        a[64*s +: 64] = {32'(s), 32'(s)};
        b[64*s +: 64] = 64'(s);
      end
      issue(mk_insn(2'd2, 4'b0010), a, b, '1);
      check("R1 per-segment lane", 64'(pred_o), 64'h11111111);
      b[63:0] = 64'd1;
      issue(mk_insn(2'd2, 4'b0010), a, b, '1);
      check("R1 only segment 0 changes", 64'(pred_o), 64'h11111100);
    end

    // R5 / R7 illegal encodings
    issue(mk_insn(2'd3, 4'b0010), '0, '0, '1);
    check("R5 size 3 rejected", {valid_o, pred_we_o, illegal_o}, 3'b101);
    check("R7 size 3 pred_o zero", 64'(pred_o), 0);
    issue(mk_insn(2'd0, 4'b0000), '0, '0, '1);
    check("R4 R7 unclaimed op 0000", {valid_o, pred_we_o, illegal_o}, 3'b101);
    issue(mk_insn(2'd0, 4'b1010), '0, '0, '1);
    check("R4 R7 unclaimed op 1010", {valid_o, pred_we_o, illegal_o}, 3'b101);
    issue(mk_insn(2'd0, 4'b0010) | 32'h0020_0000, '0, '0, '1);
    check("R4 R7 bit 21 set", {valid_o, pred_we_o, illegal_o}, 3'b101);
    issue(mk_insn(2'd0, 4'b0010) ^ 32'h0100_0000, '0, '0, '1);
    check("R4 R7 wrong top byte", {valid_o, pred_we_o, illegal_o}, 3'b101);

    // R8 idle cycle after a request
    issue(mk_insn(2'd0, 4'b0010), '0, '0, '1);
    @(negedge clk);
    check("R8 idle outputs quiet", {valid_o, pred_we_o, illegal_o}, 3'b000);
    check("R8 pred_o holds when idle", 64'(pred_o), 64'hffffffff);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule